// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block samples 24 asynchronous input pins arranged as three banks of eight and turns any level change on a selected pin into a sticky per-bank flag. Each bank has its own byte-wide pin-select register. A 3-bit bank enable register and the global interrupt enable input decide whether a set flag is presented to the interrupt controller as a request. The middle bank has only seven usable pins; the eighth position in that bank is absent and never produces anything.

Software reaches all registers over a simple byte-wide bus: address, write strobe, write data and combinational read data. A flag is cleared either by the interrupt dispatcher pulsing the acknowledge line of that bank or by software writing a one to the flag bit. Every pin passes through a two-flop synchronizer before its edge is detected, so a pin change becomes visible in the flag register on the third rising clock edge after the pin moves.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: After reset the enable register, the flag register, all three pin-select registers and irq_req read as zero.
- R2: The enable register sits at address 0x68 and the flag register at 0x3B; in both, bit g (g = 0, 1, 2) belongs to bank g, while bits 7:3 read as zero and ignore writes.
- R3: Pin-select registers for banks 0, 1 and 2 sit at addresses 0x6B, 0x6C and 0x6D and read back what was written, except that bit 7 of the bank 1 register always reads zero.
- R4: Bank 0 covers pin_in[7:0], bank 1 covers pin_in[14:8] and bank 2 covers pin_in[23:16]; pin-select bit b of bank g governs pin_in[8*g+b]; pin_in[15] never sets any flag.
- R5: A rising or a falling change on a selected pin of bank g sets flag bit g; the flag reads one after the third rising clock edge following the pin change and still reads zero after the second.
- R6: A change on a pin whose select bit is zero leaves every flag bit unchanged.
- R7: irq_req[g] is one exactly when flag bit g, enable bit g and gie are all one; flags set regardless of enable bit and gie.
- R8: A one on irq_ack[g] during a clock edge clears flag bit g at that edge.
- R9: A bus write to the flag register clears each flag bit whose write-data bit is one and leaves bits written with zero unchanged.
- R10: When a change event of bank g and a clear of flag g (acknowledge or write of one) meet at the same edge, flag g ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 24 | Asynchronous monitored pins, bank g at bits 8*g+7 down to 8*g |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 3 | Per-bank service acknowledge, clears the bank flag |
| irq_req | output | 3 | Per-bank interrupt request |

## Verification
The bench sweeps every pin position of every bank with its select bit on and off and with both edge directions, so a design that wired a pin to the wrong bank, sensed only one edge direction or let pin 15 through would set the wrong flag bit or set one where none is expected. It samples the flag register one edge before and exactly at the edge the synchronizer makes it appear, catching a missing or extra flop stage. It drives a change event into the same edge as an acknowledge and as a write-one clear; a design giving the clear priority would drop the event and read the flag as zero. It also writes zeros and ones across the reserved bits and the absent bank 1 select bit, where a design storing them would read them back.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  localparam int NGRP          = 3;
  localparam int PINS_PER_GRP  = 8;
  localparam int NPINS         = NGRP * PINS_PER_GRP;
  localparam int ADDR_W        = 8;
  localparam int DATA_W        = 8;

  // Pins that physically exist in a bank; bank 1 lacks its top pin.
  function automatic logic [PINS_PER_GRP-1:0] grp_valid_pins(input int g);
    logic [PINS_PER_GRP-1:0] v;
    v = '1;
    if (g == 1) v[PINS_PER_GRP-1] = 1'b0;
    return v;
  endfunction

  // A bank event: any existing, selected pin changed level.
  function automatic logic grp_hit(input logic [PINS_PER_GRP-1:0] chg,
                                   input logic [PINS_PER_GRP-1:0] sel,
                                   input logic [PINS_PER_GRP-1:0] valid);
    return |(chg & sel & valid);
  endfunction

  // Sticky flag: a new event wins over a simultaneous clear.
  function automatic logic flag_update(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_chg
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign pin_chg = sync_q ^ prev_q;
endmodule

// File: rtl/pinchg_group.sv
module pinchg_group
  import pinchg_pkg::*;
#(
  parameter int                 W     = PINS_PER_GRP,
  parameter logic [W-1:0]       VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_chg,
  input  logic         sel_we,
  input  logic [W-1:0] sel_wd,
  input  logic         flag_clr,
  output logic [W-1:0] sel_q,
  output logic         grp_event,
  output logic         flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_wd & VALID;
  end

  assign grp_event = grp_hit(pin_chg, sel_q, VALID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_update(flag_q, grp_event, flag_clr);
  end
endmodule

// File: rtl/pinchg_irq_ctrl.sv
module pinchg_irq_ctrl
  import pinchg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h68,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h3B,
  parameter logic [ADDR_W-1:0] SEL_BASE  = 8'h6B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gie,
  input  logic [NGRP-1:0]   irq_ack,
  output logic [NGRP-1:0]   irq_req
);
  localparam int W = PINS_PER_GRP;

  logic [NPINS-1:0]  pin_chg;
  logic [NGRP-1:0]   ctrl_q;
  logic [NGRP-1:0]   flag_q;
  logic [NGRP-1:0]   grp_event;
  logic [NGRP-1:0]   flag_clr;
  logic [W-1:0]      sel_q [NGRP];
  logic              ctrl_wr;
  logic              flag_wr;

  assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);
  assign flag_wr = bus_we && (bus_addr == FLAG_ADDR);

  pinchg_sync #(.W(NPINS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_in),
    .pin_chg   (pin_chg)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic sel_we;
    assign sel_we      = bus_we && (bus_addr == SEL_BASE + ADDR_W'(g));
    assign flag_clr[g] = irq_ack[g] | (flag_wr & bus_wdata[g]);

    pinchg_group #(.W(W), .VALID(grp_valid_pins(g))) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_chg   (pin_chg[g*W +: W]),
      .sel_we    (sel_we),
      .sel_wd    (bus_wdata[W-1:0]),
      .flag_clr  (flag_clr[g]),
      .sel_q     (sel_q[g]),
      .grp_event (grp_event[g]),
      .flag_q    (flag_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata[NGRP-1:0];
  end

  assign irq_req = flag_q & ctrl_q & {NGRP{gie}};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) bus_rdata = DATA_W'(ctrl_q);
    if (bus_addr == FLAG_ADDR) bus_rdata = DATA_W'(flag_q);
    for (int g = 0; g < NGRP; g++) begin
      if (bus_addr == SEL_BASE + ADDR_W'(g)) bus_rdata = DATA_W'(sel_q[g]);
    end
  end
endmodule

// File: rtl/pinchg_irq_ctrl_chk.sv
module pinchg_irq_ctrl_chk
  import pinchg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h68,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h3B
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              gie,
  input logic [NGRP-1:0]   irq_ack,
  input logic [NGRP-1:0]   irq_req,
  input logic [NGRP-1:0]   grp_event,
  input logic [NGRP-1:0]   flag_q
);
  // R2: reserved bits of enable and flag registers read zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == CTRL_ADDR) || (bus_addr == FLAG_ADDR)) |-> (bus_rdata[DATA_W-1:NGRP] == '0));

  // R7: no request while gie is low, none without its flag
  assert_gie_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0));
  assert_req_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~flag_q) == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R5 and R10: an event always leaves its flag set
    assert_event_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grp_event[g] |=> flag_q[g]);
    // R6: no flag rises without an event of its bank
    assert_no_spurious_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_event[g] |=> !$rose(flag_q[g]));
    // R8: acknowledge clears when no event competes
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[g] && !grp_event[g]) |=> !flag_q[g]);
    // R9: write of one clears, write of zero keeps
    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == FLAG_ADDR && bus_wdata[g] && !grp_event[g]) |=> !flag_q[g]);
    assert_w0_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == FLAG_ADDR && !bus_wdata[g] && !irq_ack[g] && flag_q[g]) |=> flag_q[g]);
  end
endmodule

bind pinchg_irq_ctrl pinchg_irq_ctrl_chk #(
  .CTRL_ADDR (CTRL_ADDR),
  .FLAG_ADDR (FLAG_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .gie       (gie),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req),
  .grp_event (grp_event),
  .flag_q    (flag_q)
);

// File: tb/test_pinchg_irq_ctrl.sv
module test_pinchg_irq_ctrl;
  localparam logic [7:0] A_CTRL = 8'h68;
  localparam logic [7:0] A_FLAG = 8'h3B;
  localparam logic [7:0] A_SEL0 = 8'h6B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        gie = 1'b0;
  logic [2:0]  irq_ack = '0;
  logic [2:0]  irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  pinchg_irq_ctrl i_pinchg_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie(gie), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // Expected bank flag for a change on pin b of bank g with select state s.
  function automatic logic [7:0] exp_flag(input int g, input int b, input bit s);
    bit exists;
    exists = !(g == 1 && b == 7);
    return (s && exists) ? 8'(1 << g) : 8'h00;
  endfunction

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1: reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(A_FLAG, v); chk("R1 flag", v, 8'h00);
    for (int g = 0; g < 3; g++) begin
      rd(A_SEL0 + 8'(g), v); chk("R1 sel", v, 8'h00);
    end
    chk("R1 irq", {5'b0, irq_req}, 8'h00);

    // R2: reserved bits
    wr(A_CTRL, 8'hFF); rd(A_CTRL, v); chk("R2 ctrl reserved", v, 8'h07);
    wr(A_CTRL, 8'hA2); rd(A_CTRL, v); chk("R2 ctrl bits", v, 8'h02);
    wr(A_CTRL, 8'h00);
    wr(A_FLAG, 8'hF8); rd(A_FLAG, v); chk("R2 flag reserved", v, 8'h00);

    // R3: select registers
    for (int g = 0; g < 3; g++) wr(A_SEL0 + 8'(g), 8'hFF);
    for (int g = 0; g < 3; g++) begin
      rd(A_SEL0 + 8'(g), v); chk("R3 sel ones", v, (g == 1) ? 8'h7F : 8'hFF);
    end
    for (int g = 0; g < 3; g++) wr(A_SEL0 + 8'(g), 8'hA5 ^ 8'(g));
    for (int g = 0; g < 3; g++) begin
      rd(A_SEL0 + 8'(g), v);
      chk("R3 sel pattern", v, (8'hA5 ^ 8'(g)) & ((g == 1) ? 8'h7F : 8'hFF));
    end

    // R4 R5 R6 R7 sweep: each pin, select off/on, both edge directions
    for (int g = 0; g < 3; g++) begin
      for (int b = 0; b < 8; b++) begin
        for (int s = 0; s < 2; s++) begin
          wr(A_SEL0 + 8'(g), (s != 0) ? 8'(1 << b) : 8'h00);
          for (int e = 0; e < 2; e++) begin
            pin_in[8*g + b] = ~pin_in[8*g + b];
            tick(); tick();
            rd(A_FLAG, v); chk("R5 not before third edge", v, 8'h00);
            tick();
            rd(A_FLAG, v);
            chk((s != 0) ? "R4 R5 selected pin change" : "R6 unselected pin change",
                v, exp_flag(g, b, s != 0));
            chk("R7 no req while disabled", {5'b0, irq_req}, 8'h00);
            wr(A_FLAG, 8'h07);
            rd(A_FLAG, v); chk("R9 clear after sweep", v, 8'h00);
          end
        end
        wr(A_SEL0 + 8'(g), 8'h00);
      end
    end

    // R7 R8: request gating and acknowledge
    for (int g = 0; g < 3; g++) begin
      wr(A_SEL0 + 8'(g), 8'h01);
      for (int c = 0; c < 4; c++) begin
        pin_in[8*g] = ~pin_in[8*g];
        repeat (3) tick();
        wr(A_CTRL, (c[0]) ? 8'(1 << g) : 8'h00);
        gie = c[1];
        #0.5;
        chk("R7 req gating", {5'b0, irq_req}, (c == 3) ? 8'(1 << g) : 8'h00);
        irq_ack[g] = 1'b1; tick(); irq_ack = '0;
        rd(A_FLAG, v); chk("R8 ack clears", v, 8'h00);
        chk("R8 req drops", {5'b0, irq_req}, 8'h00);
        gie = 1'b0;
      end
      wr(A_CTRL, 8'h00);
      wr(A_SEL0 + 8'(g), 8'h00);
    end

    // R9: write zero keeps, write one clears selectively
    wr(A_SEL0, 8'h01); wr(A_SEL0 + 8'd2, 8'h01);
    pin_in[0] = ~pin_in[0]; pin_in[16] = ~pin_in[16];
    repeat (3) tick();
    rd(A_FLAG, v); chk("R9 preset", v, 8'h05);
    wr(A_FLAG, 8'h00); rd(A_FLAG, v); chk("R9 write zero keeps", v, 8'h05);
    wr(A_FLAG, 8'h04); rd(A_FLAG, v); chk("R9 write one clears bit2", v, 8'h01);
    wr(A_FLAG, 8'h01); rd(A_FLAG, v); chk("R9 write one clears bit0", v, 8'h00);

    // R10: event meets acknowledge at the same edge
    pin_in[0] = ~pin_in[0]; repeat (3) tick();
    pin_in[0] = ~pin_in[0]; tick(); tick();
    irq_ack[0] = 1'b1; tick(); irq_ack = '0;
    rd(A_FLAG, v); chk("R10 event beats ack", v, 8'h01);
    irq_ack[0] = 1'b1; tick(); irq_ack = '0;
    rd(A_FLAG, v); chk("R10 ack alone clears", v, 8'h00);

    // R10: event meets write-one clear at the same edge
    pin_in[16] = ~pin_in[16]; repeat (3) tick();
    pin_in[16] = ~pin_in[16]; tick(); tick();
    wr(A_FLAG, 8'h04);
    rd(A_FLAG, v); chk("R10 event beats write clear", v, 8'h04);
    wr(A_FLAG, 8'h04);
    rd(A_FLAG, v); chk("R10 write alone clears", v, 8'h00);

    // R4: pin 15 with every select bit written as one
    wr(A_SEL0 + 8'd1, 8'hFF);
    pin_in[15] = ~pin_in[15]; repeat (4) tick();
    rd(A_FLAG, v); chk("R4 pin15 absent", v, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule